// File: doc/BRIEF.md
# Auxiliary Edge Recorder with Throttle Control

This block watches four auxiliary input lines and turns each configured transition into an event record. A record carries the channel number, the edge direction and a timestamp taken from a free-running counter supplied from outside. Records leave through a valid/ready handshake. Each channel has a 4-bit setting field in a 32-bit configuration word, plus one alternate-source select bit. The field enables rising capture, falling capture, sensitivity to throttling, and a channel-specific extra function.

Two channels have extra functions. When the extra bit of channel 2 is set, its input is forwarded to a test-pulse output. When the extra bit of channel 3 is set, its input takes part in the global throttle state, together with an external throttle request. The alternate-source bit of channel 1 switches it to a pulser-activity monitor. The alternate-source bit of channel 3 switches it to the block's own throttle output, as a loop-back.

Every source passes through a two-flop synchronizer. A detected edge is parked in a per-channel pending slot. A small output machine with two states serves the slots in fixed priority, lowest channel first:

- **IDLE**: the output is empty. The transition *grant* is taken when any slot is pending. It loads the lowest pending slot into the output record, clears that slot and moves to **SEND**.
- **SEND**: the record is valid and held steady. The transition *accept* is taken when ready is high, and returns the machine to IDLE.

Top module: `aux_edge_recorder`

## Requirements
- R1: After reset, evt_valid, throttle_out, test_pulse_out and every bit of ovf_flags are 0.
- R2: The field of channel c sits at cfg_word[16+4c +: 4]. Bit 0 of the field enables rising-edge capture and bit 1 enables falling-edge capture. A transition whose direction is not enabled produces no event.
- R3: An edge seen on a source raises evt_valid after the fourth rising clock edge. The record gives evt_chan = c (binary), evt_fall = 1 for a falling edge and 0 for a rising edge, and evt_ts = ts_in.
- R4: While evt_valid is high and evt_ready is low, evt_valid, evt_chan, evt_fall and evt_ts stay unchanged. A cycle with both high consumes the record.
- R5: When several channels are pending, the lowest channel number is delivered first.
- R6: While throttle_out is high, a channel with field bit 2 set discards its edges. A channel with bit 2 clear keeps reporting.
- R7: throttle_out is registered. It is high one cycle after thr_req is high, or after the synchronized channel-3 source is high while cfg_word[31] (channel 3 extra) is set.
- R8: test_pulse_out follows the synchronized channel-2 source while cfg_word[27] (channel 2 extra) is set. It is 0 otherwise.
- R9: With cfg_word[1] set, channel 1 takes pulser_mon and ignores aux_in[1]. With cfg_word[3] set, channel 3 takes throttle_out.
- R10: An edge on a channel whose pending slot is still occupied is discarded and sets ovf_flags[c]. That flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aux_in | input | 4 | Auxiliary input lines |
| pulser_mon | input | 1 | Pulser-activity monitor, alternate source of channel 1 |
| ts_in | input | TS_W | Timestamp counter |
| cfg_word | input | 32 | Configuration word |
| thr_req | input | 1 | External throttle request |
| evt_valid | output | 1 | Event record valid |
| evt_ready | input | 1 | Consumer ready |
| evt_chan | output | 2 | Channel of the event |
| evt_fall | output | 1 | 1 for a falling edge |
| evt_ts | output | TS_W | Timestamp of the event |
| throttle_out | output | 1 | Global throttle state |
| test_pulse_out | output | 1 | Forwarded channel-2 source |
| ovf_flags | output | 4 | Sticky per-channel overflow |

## Verification
A source change reaches the synchronizer output after two edges and the pending slot on the third. The record is valid after the fourth. Throttle and test-pulse outputs follow on the third edge. The bench drives inputs and samples outputs on falling clock edges. It waits six cycles for events and four for the level outputs, which is past each due cycle. Because the record is held until consumed, that margin does not affect the results. After each consume it waits three cycles before the next check, so a waiting slot has time to be granted.

// File: rtl/aux_rec_pkg.sv
package aux_rec_pkg;

    localparam int CFG_BASE  = 16;
    localparam int FIELD_W   = 4;

    typedef struct packed {
        logic extra;
        logic thr_sens;
        logic fall_en;
        logic rise_en;
    } ch_cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } out_state_t;

    function automatic ch_cfg_t cfg_field(input logic [31:0] word, input int ch);
        return ch_cfg_t'(word[CFG_BASE + FIELD_W*ch +: FIELD_W]);
    endfunction

endpackage

// File: rtl/aux_sync.sv
module aux_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/aux_chan_capture.sv
module aux_chan_capture
    import aux_rec_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            level,
    input  ch_cfg_t         cfg,
    input  logic            throttle,
    input  logic [TS_W-1:0] ts,
    input  logic            grant,
    output logic            pend,
    output logic            pend_fall,
    output logic [TS_W-1:0] pend_ts,
    output logic            ovf
);
    logic prev;
    logic rise_seen, fall_seen, hit, drop, take, busy;

    always_comb begin
        rise_seen = level & ~prev;
        fall_seen = ~level & prev;
        hit       = (rise_seen & cfg.rise_en) | (fall_seen & cfg.fall_en);
        drop      = hit & cfg.thr_sens & throttle;
        take      = hit & ~drop;
        busy      = pend & ~grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev      <= 1'b0;
            pend      <= 1'b0;
            pend_fall <= 1'b0;
            pend_ts   <= '0;
            ovf       <= 1'b0;
        end else begin
            prev <= level;
            if (grant) pend <= 1'b0;
            if (take) begin
                if (busy) begin
                    ovf <= 1'b1;
                end else begin
                    pend      <= 1'b1;
                    pend_fall <= fall_seen;
                    pend_ts   <= ts;
                end
            end
        end
    end

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R5
    grant_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> pend);

    // R6
    throttled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle && cfg.thr_sens && !pend) |=> !pend);
endmodule

// File: rtl/aux_evt_arb.sv
module aux_evt_arb
    import aux_rec_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int TS_W = 16,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CH-1:0]            pend,
    input  logic [N_CH-1:0]            pend_fall,
    input  logic [N_CH-1:0][TS_W-1:0]  pend_ts,
    input  logic                       evt_ready,
    output logic [N_CH-1:0]            grant,
    output logic                       evt_valid,
    output logic [CH_W-1:0]            evt_chan,
    output logic                       evt_fall,
    output logic [TS_W-1:0]            evt_ts
);
    out_state_t      state, nxt;
    logic [CH_W-1:0] sel;
    logic            found;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (pend[i] && !found) begin
                sel   = CH_W'(i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = found ? ST_SEND : ST_IDLE;
            ST_SEND: nxt = evt_ready ? ST_IDLE : ST_SEND;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign grant     = (state == ST_IDLE && found) ? (N_CH'(1) << sel) : '0;
    assign evt_valid = (state == ST_SEND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_chan <= '0;
            evt_fall <= 1'b0;
            evt_ts   <= '0;
        end else if (state == ST_IDLE && found) begin
            evt_chan <= sel;
            evt_fall <= pend_fall[sel];
            evt_ts   <= pend_ts[sel];
        end
    end

    // R4
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=>
            (evt_valid && $stable(evt_chan) && $stable(evt_fall) && $stable(evt_ts)));

    // R5
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    generate
        for (genvar gi = 1; gi < N_CH; gi++) begin : g_prio
            // R5
            lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
                grant[gi] |-> (pend[gi-1:0] == '0));
        end
    endgenerate
endmodule

// File: rtl/aux_edge_recorder.sv
module aux_edge_recorder
    import aux_rec_pkg::*;
#(
    parameter int TS_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      aux_in,
    input  logic            pulser_mon,
    input  logic [TS_W-1:0] ts_in,
    input  logic [31:0]     cfg_word,
    input  logic            thr_req,
    output logic            evt_valid,
    input  logic            evt_ready,
    output logic [1:0]      evt_chan,
    output logic            evt_fall,
    output logic [TS_W-1:0] evt_ts,
    output logic            throttle_out,
    output logic            test_pulse_out,
    output logic [3:0]      ovf_flags
);
    localparam int N_CH     = 4;
    localparam int TP_CH    = 2;
    localparam int THR_CH   = 3;
    localparam int PULSE_CH = 1;

    ch_cfg_t                   ch_cfg [N_CH];
    logic [N_CH-1:0]           src, src_sync;
    logic [N_CH-1:0]           pend, pend_fall, grant;
    logic [N_CH-1:0][TS_W-1:0] pend_ts;
    logic                      thr_q, tp_q;
    logic                      unused_cfg;

    assign unused_cfg = ^cfg_word[15:4];

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_src
            assign ch_cfg[c] = cfg_field(cfg_word, c);
            if (c == PULSE_CH) begin : g_alt_pulse
                assign src[c] = cfg_word[c] ? pulser_mon : aux_in[c];
            end else if (c == THR_CH) begin : g_alt_loop
                assign src[c] = cfg_word[c] ? thr_q : aux_in[c];
            end else begin : g_plain
                assign src[c] = aux_in[c];
            end
        end
    endgenerate

    aux_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src),
        .q     (src_sync)
    );

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_chan
            aux_chan_capture #(.TS_W(TS_W)) cap_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .level     (src_sync[c]),
                .cfg       (ch_cfg[c]),
                .throttle  (thr_q),
                .ts        (ts_in),
                .grant     (grant[c]),
                .pend      (pend[c]),
                .pend_fall (pend_fall[c]),
                .pend_ts   (pend_ts[c]),
                .ovf       (ovf_flags[c])
            );
        end
    endgenerate

    aux_evt_arb #(.N_CH(N_CH), .TS_W(TS_W)) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .pend_fall (pend_fall),
        .pend_ts   (pend_ts),
        .evt_ready (evt_ready),
        .grant     (grant),
        .evt_valid (evt_valid),
        .evt_chan  (evt_chan),
        .evt_fall  (evt_fall),
        .evt_ts    (evt_ts)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= 1'b0;
            tp_q  <= 1'b0;
        end else begin
            thr_q <= thr_req | (src_sync[THR_CH] & ch_cfg[THR_CH].extra);
            tp_q  <= src_sync[TP_CH] & ch_cfg[TP_CH].extra;
        end
    end

    assign throttle_out   = thr_q;
    assign test_pulse_out = tp_q;

    // R7
    thr_req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_req |=> throttle_out);

    // R8
    tp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_word[27] |=> !test_pulse_out);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!evt_valid && !throttle_out && ovf_flags == '0));
endmodule

// File: tb/aux_edge_recorder_tb_top.sv
module aux_edge_recorder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TS_W = 16;

    typedef struct packed {
        logic [31:0] cfg;
        logic [3:0]  aux;
        logic        ev;
        logic [1:0]  chan;
        logic        fall;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h3333_0000, 4'b0001, 1'b1, 2'd0, 1'b0},
        '{32'h3333_0000, 4'b0000, 1'b1, 2'd0, 1'b1},
        '{32'h3333_0000, 4'b0100, 1'b1, 2'd2, 1'b0},
        '{32'h3133_0000, 4'b0000, 1'b0, 2'd0, 1'b0},
        '{32'h3133_0000, 4'b1000, 1'b1, 2'd3, 1'b0},
        '{32'h2133_0000, 4'b0000, 1'b1, 2'd3, 1'b1},
        '{32'h2133_0000, 4'b0010, 1'b1, 2'd1, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      aux_in = '0;
    logic            pulser_mon = 1'b0;
    logic [TS_W-1:0] ts_in = '0;
    logic [31:0]     cfg_word = 32'h3333_0000;
    logic            thr_req = 1'b0;
    logic            evt_ready = 1'b0;
    logic            evt_valid, evt_fall, throttle_out, test_pulse_out;
    logic [1:0]      evt_chan;
    logic [TS_W-1:0] evt_ts;
    logic [3:0]      ovf_flags;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_edge_recorder #(.TS_W(TS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .aux_in(aux_in), .pulser_mon(pulser_mon),
        .ts_in(ts_in), .cfg_word(cfg_word), .thr_req(thr_req),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_chan(evt_chan),
        .evt_fall(evt_fall), .evt_ts(evt_ts), .throttle_out(throttle_out),
        .test_pulse_out(test_pulse_out), .ovf_flags(ovf_flags)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic consume();
        evt_ready = 1'b1;
        tick(1);
        evt_ready = 1'b0;
        tick(3);
    endtask

    task automatic drain();
        repeat (6) begin
            if (evt_valid) consume();
            else tick(3);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        // R1 reset state
        check("R1 valid", 32'(evt_valid), 0);
        check("R1 throttle", 32'(throttle_out), 0);
        check("R1 test pulse", 32'(test_pulse_out), 0);
        check("R1 ovf", 32'(ovf_flags), 0);
        rst_n = 1'b1;
        tick(4);
        check("R1 valid after release", 32'(evt_valid), 0);

        // R2 R3 table walk
        for (int i = 0; i < NV; i++) begin
            cfg_word = VECS[i].cfg;
            aux_in   = VECS[i].aux;
            ts_in    = TS_W'(16'h1000 + i);
            tick(6);
            check("R2 valid", 32'(evt_valid), 32'(VECS[i].ev));
            if (VECS[i].ev) begin
                check("R3 chan", 32'(evt_chan), 32'(VECS[i].chan));
                check("R3 fall", 32'(evt_fall), 32'(VECS[i].fall));
                check("R3 ts", 32'(evt_ts), 32'h1000 + i);
                tick(3);
                check("R4 held", 32'(evt_valid), 1);
                consume();
            end
            check("R4 consumed", 32'(evt_valid), 0);
        end
        cfg_word = 32'h3333_0000;
        aux_in = 4'b0000;
        tick(6);
        drain();

        // R3 latency: not valid after three edges, valid after four
        aux_in = 4'b0001;
        tick(3);
        check("R3 not yet", 32'(evt_valid), 0);
        tick(1);
        check("R3 due", 32'(evt_valid), 1);
        consume();
        aux_in = 4'b0000;
        tick(6);
        drain();

        // R5 priority
        aux_in = 4'b1010;
        tick(6);
        check("R5 first", 32'(evt_chan), 1);
        consume();
        check("R5 second valid", 32'(evt_valid), 1);
        check("R5 second", 32'(evt_chan), 3);
        consume();
        aux_in = 4'b0000;
        tick(6);
        drain();

        // R10 overflow
        aux_in = 4'b0001; tick(6);
        aux_in = 4'b0000; tick(6);
        check("R10 no ovf yet", 32'(ovf_flags), 0);
        aux_in = 4'b0001; tick(6);
        check("R10 ovf set", 32'(ovf_flags), 1);
        check("R10 first chan0 rise", 32'(evt_fall), 0);
        consume();
        check("R10 second fall", 32'(evt_fall), 1);
        consume();
        check("R10 third dropped", 32'(evt_valid), 0);
        aux_in = 4'b0000; tick(6);
        drain();
        check("R10 sticky", 32'(ovf_flags), 1);

        // R6 R7 throttle
        thr_req = 1'b1;
        cfg_word = 32'h3337_0000;
        tick(3);
        check("R7 thr_req", 32'(throttle_out), 1);
        aux_in = 4'b0001; tick(6);
        check("R6 sensitive dropped", 32'(evt_valid), 0);
        aux_in = 4'b0011; tick(6);
        check("R6 other reports", 32'(evt_valid), 1);
        check("R6 other chan", 32'(evt_chan), 1);
        consume();
        thr_req = 1'b0;
        tick(3);
        check("R7 release", 32'(throttle_out), 0);
        cfg_word = 32'h3333_0000;
        aux_in = 4'b0000; tick(6);
        drain();

        // R7 channel-3 extra
        cfg_word = 32'h8333_0000;
        aux_in = 4'b1000; tick(4);
        check("R7 ch3 throttle", 32'(throttle_out), 1);
        check("R2 ch3 disabled", 32'(evt_valid), 0);
        aux_in = 4'b0000; tick(4);
        check("R7 ch3 release", 32'(throttle_out), 0);

        // R8 test pulse
        cfg_word = 32'h3833_0000;
        aux_in = 4'b0100; tick(4);
        check("R8 forwarded", 32'(test_pulse_out), 1);
        cfg_word = 32'h3033_0000; tick(2);
        check("R8 off", 32'(test_pulse_out), 0);
        aux_in = 4'b0000; tick(6);
        check("R2 ch2 disabled", 32'(evt_valid), 0);

        // R9 pulser monitor on channel 1
        cfg_word = 32'h3333_0002;
        pulser_mon = 1'b1; tick(6);
        check("R9 pulser event", 32'(evt_valid), 1);
        check("R9 pulser chan", 32'(evt_chan), 1);
        consume();
        aux_in = 4'b0010; tick(6);
        check("R9 aux1 ignored", 32'(evt_valid), 0);
        pulser_mon = 1'b0; tick(6);
        drain();
        cfg_word = 32'h3333_0000; tick(6);
        drain();
        aux_in = 4'b0000; tick(6);
        drain();

        // R9 throttle loop-back on channel 3
        cfg_word = 32'h3333_0008;
        thr_req = 1'b1; tick(8);
        check("R9 loopback event", 32'(evt_valid), 1);
        check("R9 loopback chan", 32'(evt_chan), 3);
        check("R9 loopback rise", 32'(evt_fall), 0);
        consume();
        thr_req = 1'b0; tick(8);
        check("R9 loopback fall", 32'(evt_fall), 1);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule